// File: doc/BRIEF.md
# Dual-Bank Image Validator and Selector

This block decides which of two stored copies of a configuration image is trustworthy and current. After a start pulse it reads both banks from a byte-wide synchronous memory port, bank 0 first and then bank 1, one byte per cycle. For each bank it checks three things:

- a fixed signature byte;
- an 8-bit end-around-carry checksum over the header;
- a 32-bit two-sum modular checksum over the body.

It then reports per bank whether the bank is valid and which generation number it carries. From those results it picks the bank to use. When neither bank passes, it raises an error flag.

Each bank holds `BANK_BYTES` bytes, and `BANK_BYTES` must be a power of two. Bank 0 lives at memory addresses 0 to `BANK_BYTES-1` and bank 1 directly above it, so the top address bit names the bank. Multi-byte fields are stored most significant byte first. The bank layout is as follows:

| Offset | Content |
|--------|---------|
| 0 | signature |
| 1 | header check byte |
| 2 to 3 | length field |
| 4 to 7 | stored body checksum |
| 8 to 11 | generation number |
| 8 to the end | body covered by the body checksum |

All results stay on the outputs until the next run overwrites them.

Top module: `dual_image_validator`

## Requirements
- R1: A start pulse accepted while idle makes the block issue `2*BANK_BYTES` reads on consecutive cycles starting in the cycle after the accepting edge, with `mem_addr` stepping 0, 1, 2 … `2*BANK_BYTES-1`. No read is issued at any other time. Read data is expected on `mem_rdata` one cycle after `mem_rd_en`.
- R2: A bank whose byte at offset 0 differs from `SIG_VALUE` is reported invalid.
- R3: The header check starts from the offset-0 byte and adds the bytes at offsets 2 and 3. While the sum is above 0xFF, it is replaced by its low byte plus the bits above the low byte. A bank whose result differs from the byte at offset 1 is invalid.
- R4: The body check starts with a low sum of 1 and a high sum of 0. For every byte from offset 8 to the end of the bank, the low sum gains the byte and the high sum then gains the low sum. Both sums are taken modulo 65521, and the result is high in bits 31:16 and low in bits 15:0. A bank whose result differs from offsets 4..7 (most significant byte first) is invalid.
- R5: A valid bank reports its generation from offsets 8..11, most significant byte first. An invalid bank reports all ones. `bank_valid[i]` reflects bank i.
- R6: `sel_bank` is 0 when bank 0 is valid and either bank 1 is invalid or bank 0's generation is strictly greater as an unsigned number. Otherwise `sel_bank` is 1, which includes the case of equal generations.
- R7: `both_bad` is 1 exactly when both banks are invalid.
- R8: `done` is a one-cycle pulse in the cycle `2*BANK_BYTES+3` cycles after the accepting edge, which is the same moment `sel_bank` and `both_bad` update. A start pulse that arrives before that cycle is ignored.
- R9: After reset, `done`, `mem_rd_en`, both `bank_valid` bits, `sel_bank` and `both_bad` are 0, and both generation outputs are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a validation run (ignored while a run is in progress) |
| mem_rd_en | output | 1 | Read strobe to the image memory |
| mem_addr | output | AW = log2(2*BANK_BYTES) | Read address, top bit selects the bank |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle pulse when the selection is ready |
| bank_valid | output | 2 | Per-bank pass flag, bit i for bank i |
| bank0_gen | output | 32 | Generation of bank 0, all ones when invalid |
| bank1_gen | output | 32 | Generation of bank 1, all ones when invalid |
| sel_bank | output | 1 | Index of the bank to use |
| both_bad | output | 1 | Neither bank passed |

## Verification
The bench builds the block with `BANK_BYTES = 512` and `SIG_VALUE = 8'hA5`. With 504 body bytes, a body filled with 0xFF pushes the low sum past 65521 (the high sum wraps in every case), so the reduction step is really exercised. Length bytes of 0xFF force the header fold to carry. Generation values up to 0xFFFFFFFF probe the unsigned comparison, equal generations probe the tie rule, and a second start pulse in the middle of a run probes the ignore rule.

// File: rtl/dual_image_validator_pkg.sv
`timescale 1ns/1ps
package dual_image_validator_pkg;

  // Byte offsets inside one bank; the checking logic decodes these.
  localparam int unsigned OFS_SIG      = 0;
  localparam int unsigned OFS_HDR_CK   = 1;
  localparam int unsigned OFS_HDR_SUM0 = 2;
  localparam int unsigned OFS_BODY_CK  = 4;
  localparam int unsigned OFS_GEN      = 8;
  localparam int unsigned GEN_BYTES    = 4;
  localparam int unsigned GEN_W        = 8 * GEN_BYTES;

  localparam logic [16:0] BODY_MOD = 17'd65521;

  // Add a byte into an 8-bit end-around-carry sum; one fold is enough
  // because the sum of two bytes never exceeds 0x1FE.
  function automatic logic [7:0] fold_add8(input logic [7:0] acc, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, acc} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  // Modular add of two residues below BODY_MOD; one subtraction suffices.
  function automatic logic [15:0] mod_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= BODY_MOD) s = s - BODY_MOD;
    return s[15:0];
  endfunction

  // Bank 0 wins only when valid and either alone or strictly newer.
  function automatic logic pick_bank1(input logic ok0, input logic ok1,
                                      input logic [GEN_W-1:0] g0, input logic [GEN_W-1:0] g1);
    logic take0;
    take0 = ok0 && (!ok1 || (g0 > g1));
    return !take0;
  endfunction

endpackage

// File: rtl/ivs_fetch_seq.sv
`timescale 1ns/1ps
module ivs_fetch_seq #(
  parameter  int BANK_BYTES = 256,
  localparam int TOTAL      = 2 * BANK_BYTES,
  localparam int AW         = $clog2(TOTAL),
  localparam int OW         = $clog2(BANK_BYTES),
  localparam int CW         = $clog2(TOTAL + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          strm_vld,
  output logic          strm_bank,
  output logic [OW-1:0] strm_ofs,
  output logic          eval_vld,
  output logic          eval_bank
);

  localparam logic [CW-1:0] RUN_END   = CW'(TOTAL + 2);
  localparam logic [OW-1:0] LAST_OFS  = OW'(BANK_BYTES - 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(TOTAL - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;
  logic          accept;

  assign accept  = start && !run_q;
  assign rd_en   = run_q && (cnt_q < CW'(TOTAL));
  assign rd_addr = cnt_q[AW-1:0];

  // The run spans the reads plus the result pipeline, so a start pulse
  // cannot restart the walk before the selection is out.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (accept) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == RUN_END) run_q <= 1'b0;
      else                  cnt_q <= cnt_q + 1'b1;
    end
  end

  // Tag the returning byte with bank and offset (read latency one).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strm_vld  <= 1'b0;
      strm_bank <= 1'b0;
      strm_ofs  <= '0;
      eval_vld  <= 1'b0;
      eval_bank <= 1'b0;
    end else begin
      strm_vld  <= rd_en;
      strm_bank <= rd_addr[AW-1];
      strm_ofs  <= rd_addr[OW-1:0];
      eval_vld  <= strm_vld && (strm_ofs == LAST_OFS);
      eval_bank <= strm_bank;
    end
  end

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != LAST_ADDR) |=> (rd_en && rd_addr == $past(rd_addr) + 1'b1));

  p_first_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> (rd_addr == '0));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LAST_ADDR) |=> !rd_en);

endmodule

// File: rtl/ivs_stream_check.sv
`timescale 1ns/1ps
module ivs_stream_check
  import dual_image_validator_pkg::*;
#(
  parameter  int         BANK_BYTES = 256,
  parameter  logic [7:0] SIG_VALUE  = 8'h5A,
  localparam int         OW         = $clog2(BANK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strm_vld,
  input  logic [OW-1:0]    strm_ofs,
  input  logic [7:0]       strm_byte,
  output logic             res_ok,
  output logic [GEN_W-1:0] res_gen
);

  logic [7:0]       sig_q, hck_q, hsum_q;
  logic [31:0]      bck_q;
  logic [15:0]      lo_q, hi_q, lo_nxt, hi_nxt;
  logic [GEN_W-1:0] gen_q;

  logic at_first, at_hck, in_hdr_sum, in_bck, in_body, in_gen;
  logic sig_good, hdr_good, body_good;

  assign at_first   = (strm_ofs == OW'(OFS_SIG));
  assign at_hck     = (strm_ofs == OW'(OFS_HDR_CK));
  assign in_hdr_sum = (strm_ofs >= OW'(OFS_HDR_SUM0)) && (strm_ofs < OW'(OFS_BODY_CK));
  assign in_bck     = (strm_ofs >= OW'(OFS_BODY_CK)) && (strm_ofs < OW'(OFS_GEN));
  assign in_body    = (strm_ofs >= OW'(OFS_GEN));
  assign in_gen     = in_body && (strm_ofs < OW'(OFS_GEN + GEN_BYTES));

  always_comb begin
    lo_nxt = mod_add16(lo_q, {8'd0, strm_byte});
    hi_nxt = mod_add16(hi_q, lo_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q  <= '0;
      hck_q  <= '0;
      hsum_q <= '0;
      bck_q  <= '0;
      lo_q   <= 16'd1;
      hi_q   <= '0;
      gen_q  <= '0;
    end else if (strm_vld) begin
      if (at_first) begin
        // The offset-0 byte seeds the header sum and opens a new bank.
        sig_q  <= strm_byte;
        hsum_q <= strm_byte;
        lo_q   <= 16'd1;
        hi_q   <= '0;
      end else if (at_hck) begin
        hck_q <= strm_byte;
      end else if (in_hdr_sum) begin
        hsum_q <= fold_add8(hsum_q, strm_byte);
      end else if (in_bck) begin
        bck_q <= {bck_q[23:0], strm_byte};
      end else if (in_body) begin
        lo_q <= lo_nxt;
        hi_q <= hi_nxt;
        if (in_gen) gen_q <= {gen_q[GEN_W-9:0], strm_byte};
      end
    end
  end

  assign sig_good  = (sig_q == SIG_VALUE);
  assign hdr_good  = (hsum_q == hck_q);
  assign body_good = (bck_q == {hi_q, lo_q});
  assign res_ok    = sig_good && hdr_good && body_good;
  assign res_gen   = gen_q;

  p_mod_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q < BODY_MOD[15:0]) && (hi_q < BODY_MOD[15:0]));

  p_body_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_vld && at_first) |=> (lo_q == 16'd1 && hi_q == 16'd0));

endmodule

// File: rtl/ivs_result_hold.sv
`timescale 1ns/1ps
module ivs_result_hold
  import dual_image_validator_pkg::*;
#(
  parameter logic BANK_IDX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_vld,
  input  logic             eval_bank,
  input  logic             ok_in,
  input  logic [GEN_W-1:0] gen_in,
  output logic             valid,
  output logic [GEN_W-1:0] gen
);

  logic mine;
  assign mine = eval_vld && (eval_bank == BANK_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      gen   <= '1;
    end else if (mine) begin
      valid <= ok_in;
      gen   <= ok_in ? gen_in : '1;
    end
  end

  p_invalid_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (&gen));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mine) |-> ($stable(valid) && $stable(gen)));

endmodule

// File: rtl/ivs_pick.sv
`timescale 1ns/1ps
module ivs_pick
  import dual_image_validator_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             ok0,
  input  logic             ok1,
  input  logic [GEN_W-1:0] gen0,
  input  logic [GEN_W-1:0] gen1,
  output logic             sel,
  output logic             err,
  output logic             done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= 1'b0;
      err  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= go;
      if (go) begin
        sel <= pick_bank1(ok0, ok1, gen0, gen1);
        err <= !ok0 && !ok1;
      end
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (!ok0 && !ok1)));

  p_lone_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok0 && !ok1) |-> !sel);

  p_bad_bank0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok0) |-> sel);

endmodule

// File: rtl/dual_image_validator.sv
`timescale 1ns/1ps
module dual_image_validator
  import dual_image_validator_pkg::*;
#(
  parameter  int         BANK_BYTES = 256,
  parameter  logic [7:0] SIG_VALUE  = 8'h5A,
  localparam int         AW         = $clog2(2 * BANK_BYTES),
  localparam int         OW         = $clog2(BANK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          done,
  output logic [1:0]    bank_valid,
  output logic [31:0]   bank0_gen,
  output logic [31:0]   bank1_gen,
  output logic          sel_bank,
  output logic          both_bad
);

  logic             strm_vld, strm_bank, eval_vld, eval_bank;
  logic [OW-1:0]    strm_ofs;
  logic             chk_ok;
  logic [GEN_W-1:0] chk_gen;
  logic [GEN_W-1:0] gen_out [2];
  logic             last_bank_done;

  ivs_fetch_seq #(.BANK_BYTES(BANK_BYTES)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_addr),
    .strm_vld  (strm_vld),
    .strm_bank (strm_bank),
    .strm_ofs  (strm_ofs),
    .eval_vld  (eval_vld),
    .eval_bank (eval_bank)
  );

  ivs_stream_check #(.BANK_BYTES(BANK_BYTES), .SIG_VALUE(SIG_VALUE)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .strm_vld  (strm_vld),
    .strm_ofs  (strm_ofs),
    .strm_byte (mem_rdata),
    .res_ok    (chk_ok),
    .res_gen   (chk_gen)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ivs_result_hold #(.BANK_IDX(1'(b))) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .eval_vld  (eval_vld),
      .eval_bank (eval_bank),
      .ok_in     (chk_ok),
      .gen_in    (chk_gen),
      .valid     (bank_valid[b]),
      .gen       (gen_out[b])
    );
  end

  assign bank0_gen = gen_out[0];
  assign bank1_gen = gen_out[1];

  // Bank 1 is checked last; its verdict triggers the choice one cycle later.
  always_ff @(posedge clk) begin
    if (!rst_n) last_bank_done <= 1'b0;
    else        last_bank_done <= eval_vld && eval_bank;
  end

  ivs_pick u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (last_bank_done),
    .ok0   (bank_valid[0]),
    .ok1   (bank_valid[1]),
    .gen0  (gen_out[0]),
    .gen1  (gen_out[1]),
    .sel   (sel_bank),
    .err   (both_bad),
    .done  (done)
  );

  p_quiet_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en);

endmodule

// File: tb/test_dual_image_validator.sv
`timescale 1ns/1ps
module test_dual_image_validator;

  localparam int         NB     = 512;
  localparam int         TOT    = 2 * NB;
  localparam int         AW     = $clog2(TOT);
  localparam logic [7:0] SIG    = 8'hA5;
  localparam int         DONE_K = TOT + 3;
  localparam int         CAP    = TOT + 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic          done;
  logic [1:0]    bank_valid;
  logic [31:0]   bank0_gen, bank1_gen;
  logic          sel_bank, both_bad;

  always #2.5 clk = ~clk;

  dual_image_validator #(.BANK_BYTES(NB), .SIG_VALUE(SIG)) i_dual_image_validator (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .bank_valid(bank_valid), .bank0_gen(bank0_gen), .bank1_gen(bank1_gen),
    .sel_bank(sel_bank), .both_bad(both_bad)
  );

  logic [7:0] mem [TOT];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural checker of one bank, written from the requirements.
  task automatic ref_bank(input int b, output bit ok, output logic [31:0] gen);
    int base, s;
    longint lo, hi;
    logic [31:0] stored;
    base = b * NB;
    s = mem[base] + mem[base+2] + mem[base+3];
    while (s > 255) s = (s & 255) + (s >> 8);
    lo = 1; hi = 0;
    for (int i = 8; i < NB; i++) begin
      lo = lo + mem[base+i];
      hi = hi + lo;
    end
    lo = lo % 65521; hi = hi % 65521;
    stored = {mem[base+4], mem[base+5], mem[base+6], mem[base+7]};
    ok = (mem[base] == SIG) && (s == int'(mem[base+1])) &&
         (stored == {hi[15:0], lo[15:0]});
    gen = ok ? {mem[base+8], mem[base+9], mem[base+10], mem[base+11]} : 32'hFFFF_FFFF;
  endtask

  // Build a well-formed bank; fill 1 puts 0xFF everywhere in length and body.
  task automatic make_bank(input int b, input logic [31:0] gen, input int fill, input int seed);
    int base, s;
    longint lo, hi;
    logic [31:0] lcg;
    base = b * NB;
    lcg = seed;
    for (int i = 2; i < NB; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      mem[base+i] = (fill == 1) ? 8'hFF : lcg[23:16];
    end
    mem[base]    = SIG;
    mem[base+8]  = gen[31:24];
    mem[base+9]  = gen[23:16];
    mem[base+10] = gen[15:8];
    mem[base+11] = gen[7:0];
    lo = 1; hi = 0;
    for (int i = 8; i < NB; i++) begin
      lo = (lo + mem[base+i]) % 65521;
      hi = (hi + lo) % 65521;
    end
    mem[base+4] = hi[15:8]; mem[base+5] = hi[7:0];
    mem[base+6] = lo[15:8]; mem[base+7] = lo[7:0];
    s = SIG + mem[base+2] + mem[base+3];
    while (s > 255) s = (s & 255) + (s >> 8);
    mem[base+1] = s[7:0];
  endtask

  // Cycle model: m_k counts cycles since the accepting edge.
  int          m_k = CAP;
  bit          checking = 1'b0;
  bit          e_ok0, e_ok1;
  logic [31:0] e_g0, e_g1;
  string       cur_req = "R6";

  always @(posedge clk) begin
    if (!rst_n)                        m_k <= CAP;
    else if (start && m_k >= DONE_K)   m_k <= 0;
    else if (m_k < CAP)                m_k <= m_k + 1;
  end

  always @(negedge clk) begin
    if (rst_n && checking) begin
      chk("R8", "done", 64'(done), 64'(m_k == DONE_K));
      chk("R1", "mem_rd_en", 64'(mem_rd_en), 64'(m_k < TOT));
      if (m_k < TOT) chk("R1", "mem_addr", 64'(mem_addr), 64'(m_k));
      if (m_k == DONE_K) begin
        chk(cur_req, "bank_valid[0]", 64'(bank_valid[0]), 64'(e_ok0));
        chk(cur_req, "bank_valid[1]", 64'(bank_valid[1]), 64'(e_ok1));
        chk("R5", "bank0_gen", 64'(bank0_gen), 64'(e_g0));
        chk("R5", "bank1_gen", 64'(bank1_gen), 64'(e_g1));
        chk("R6", "sel_bank", 64'(sel_bank),
            64'(!(e_ok0 && (!e_ok1 || e_g0 > e_g1))));
        chk("R7", "both_bad", 64'(both_bad), 64'(!e_ok0 && !e_ok1));
      end
    end
  end

  task automatic run_case(input string req, input bit extra_start);
    ref_bank(0, e_ok0, e_g0);
    ref_bank(1, e_ok1, e_g1);
    cur_req = req;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra_start) begin
      // R8: a second pulse mid-run must not restart the walk.
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    repeat (TOT + 8) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < TOT; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk("R9", "done", 64'(done), 64'd0);
    chk("R9", "mem_rd_en", 64'(mem_rd_en), 64'd0);
    chk("R9", "bank_valid", 64'(bank_valid), 64'd0);
    chk("R9", "bank0_gen", 64'(bank0_gen), 64'hFFFF_FFFF);
    chk("R9", "bank1_gen", 64'(bank1_gen), 64'hFFFF_FFFF);
    chk("R9", "sel_bank", 64'(sel_bank), 64'd0);
    chk("R9", "both_bad", 64'(both_bad), 64'd0);
    checking = 1'b1;

    // R6: bank 0 newer
    make_bank(0, 32'd5, 0, 11); make_bank(1, 32'd3, 0, 22);
    run_case("R6", 1'b0);
    // R6: equal generations pick bank 1
    make_bank(0, 32'd7, 0, 33); make_bank(1, 32'd7, 0, 44);
    run_case("R6", 1'b0);
    // R4, R3: all-0xFF fill wraps the low sum and makes the header fold carry
    make_bank(0, 32'd2, 1, 0); make_bank(1, 32'd9, 1, 0);
    run_case("R4", 1'b0);
    // R2: bad signature in bank 0
    make_bank(0, 32'd100, 0, 55); make_bank(1, 32'd1, 0, 66);
    mem[0] = mem[0] ^ 8'h01;
    run_case("R2", 1'b0);
    // R3: bad header check byte in bank 1
    make_bank(0, 32'd1, 0, 77); make_bank(1, 32'd50, 0, 88);
    mem[NB+1] = mem[NB+1] ^ 8'h08;
    run_case("R3", 1'b0);
    // R4: last body byte of bank 0 flipped
    make_bank(0, 32'd60, 0, 99); make_bank(1, 32'd4, 0, 12);
    mem[NB-1] = mem[NB-1] ^ 8'h01;
    run_case("R4", 1'b0);
    // R4: stored body checksum of bank 1 wrong
    make_bank(0, 32'd1, 0, 13); make_bank(1, 32'd40, 0, 14);
    mem[NB+5] = mem[NB+5] ^ 8'h02;
    run_case("R4", 1'b0);
    // R5: generation altered without updating the body checksum
    make_bank(0, 32'd3, 0, 15); make_bank(1, 32'd8, 0, 16);
    mem[NB+11] = mem[NB+11] ^ 8'h10;
    run_case("R5", 1'b0);
    // R7: both banks corrupt
    make_bank(0, 32'd3, 0, 17); make_bank(1, 32'd8, 0, 18);
    mem[0] = 8'h00; mem[NB+6] = mem[NB+6] ^ 8'h40;
    run_case("R7", 1'b0);
    // R6, R8: unsigned maximum against zero, with an ignored mid-run start
    make_bank(0, 32'hFFFF_FFFF, 0, 19); make_bank(1, 32'd0, 0, 20);
    run_case("R6", 1'b1);

    finish_run();
  end

endmodule